// File: doc/BRIEF.md
# Serial Port Register and Interrupt Identification Block

This block is the register set of a 16550-style serial port, seen from a byte-wide memory-mapped bus. It holds the receive buffer, transmit holding register, interrupt enable, interrupt identification, line control, modem control, line status and scratch registers. They are kept as two 32-bit words of four byte lanes each. The serial shifting, baud generation and FIFOs sit outside the block. A received byte arrives on a valid/byte input pair, and a byte written for transmission leaves on a valid/byte output pair.

The identification code is worked out again on every state change: on a bus write, a receive event, a data read or a transmit completion. The code is computed from the values the registers hold after the change, so the change and the new code become visible on the same clock edge. Two conditions are tested in a fixed priority order and give one of three codes: receive data present, transmit holding register empty, or no interrupt. An interrupt line follows the code and is meant to feed the hart's supervisor external interrupt pending bit.

The bus offsets follow the usual 16550 layout: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 unused, 7 scratch. Read data is registered. It appears on the cycle after the read strobe and shows the register contents from before that edge.

Top module: `sio_intid`

## Requirements
- R1: After a synchronous active-low reset, receive buffer, transmit holding, interrupt enable, line control, modem control and scratch registers are 0. Identification reads 0x07, line status reads 0x60, and `irq`, `tx_valid` and `bus_rdata` are 0.
- R2: `regs_lo` packs receive buffer, transmit holding, interrupt enable and identification into byte lanes 0,1,2,3 (lane 0 = bits 7:0). `regs_hi` packs line control, modem control, line status and scratch into lanes 0,1,2,3.
- R3: When the receive buffer is nonzero and interrupt enable bit 0 is set, identification reads 0x04. A received byte of 0x00 does not count as data.
- R4: Otherwise, when the transmit holding register is zero and interrupt enable bit 1 is set, identification reads 0x02.
- R5: Otherwise identification reads 0x07.
- R6: A bus write to offset 0 loads the transmit holding register and refreshes the identification code on the same edge. In the next cycle `tx_valid` is high for one cycle with the byte on `tx_byte`, and the register then returns to zero. Back-to-back writes each produce their own strobe.
- R7: `rx_valid` loads `rx_byte` into the receive buffer. A read of offset 0 returns the buffer on `bus_rdata` one cycle later and clears the buffer. When a receive and a data read share a cycle, the read returns the old byte and the buffer keeps the new one.
- R8: `irq` is 1 exactly when identification is not 0x07.
- R9: Offsets 1, 3, 4 and 7 are read/write. Offset 2 reads identification, offset 5 reads line status and offset 6 reads 0x00. Writes to offsets 2, 5 and 6 leave all state unchanged.
- R10: Line status bit 0 is 1 when the receive buffer is nonzero. Bits 5 and 6 are 1 when the transmit holding register is zero. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request to the supervisor external pending bit |
| regs_lo | output | 32 | Packed word: buffer, holding, enable, identification |
| regs_hi | output | 32 | Packed word: line control, modem control, status, scratch |

## Verification
Arrival of a received byte and a bus read of the data register can fall in the same cycle. The two update the same buffer in opposite directions. The bench first fills the buffer with one byte. It then raises `rx_valid` with a second byte and the data-register read strobe together. It judges the result by the read returning the first byte, by lane 0 of `regs_lo` holding the second, and by the identification lane staying at 0x04 with `irq` high. A transmit write that lands while the previous byte's strobe is still high is also provoked. The bench checks that the new byte wins over the clearing of the holding register.

// File: rtl/sio_intid_pkg.sv
package sio_intid_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int ADDR_W  = 3;
  localparam int N_OFS   = 1 << ADDR_W;

  // bus offsets (fixed by software compatibility)
  localparam int OFS_DATA  = 0;
  localparam int OFS_IEN   = 1;
  localparam int OFS_IDENT = 2;
  localparam int OFS_LCTL  = 3;
  localparam int OFS_MCTL  = 4;
  localparam int OFS_LSTAT = 5;
  localparam int OFS_SCR   = 7;

  // identification codes
  localparam logic [BYTE_W-1:0] ID_RXDATA = 8'h04;
  localparam logic [BYTE_W-1:0] ID_TXMT   = 8'h02;
  localparam logic [BYTE_W-1:0] ID_NONE   = 8'h07;

  // enable bits
  localparam int EN_RX_BIT = 0;
  localparam int EN_TX_BIT = 1;

  // status bits
  localparam int ST_DR_BIT   = 0;
  localparam int ST_THRE_BIT = 5;
  localparam int ST_TEMT_BIT = 6;

  function automatic logic rx_pending(input logic [BYTE_W-1:0] rbuf,
                                      input logic [BYTE_W-1:0] ien);
    return (rbuf != '0) && ien[EN_RX_BIT];
  endfunction

  function automatic logic tx_pending(input logic [BYTE_W-1:0] thold,
                                      input logic [BYTE_W-1:0] ien);
    return (thold == '0) && ien[EN_TX_BIT];
  endfunction

  function automatic logic [BYTE_W-1:0] ident_code(input logic [BYTE_W-1:0] rbuf,
                                                   input logic [BYTE_W-1:0] thold,
                                                   input logic [BYTE_W-1:0] ien);
    if (rx_pending(rbuf, ien))      return ID_RXDATA;
    else if (tx_pending(thold, ien)) return ID_TXMT;
    else                             return ID_NONE;
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic [BYTE_W-1:0] rbuf,
                                                    input logic [BYTE_W-1:0] thold);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_DR_BIT]   = (rbuf != '0);
    s[ST_THRE_BIT] = (thold == '0);
    s[ST_TEMT_BIT] = (thold == '0);
    return s;
  endfunction

endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
  import sio_intid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              thr_wr,
  output logic              ien_wr,
  output logic              lctl_wr,
  output logic              mctl_wr,
  output logic              scr_wr,
  output logic              rbuf_rd
);

  logic [N_OFS-1:0] wr_hit;

  for (genvar g = 0; g < N_OFS; g++) begin : g_hit
    assign wr_hit[g] = wr && (addr == ADDR_W'(g));
  end

  assign thr_wr  = wr_hit[OFS_DATA];
  assign ien_wr  = wr_hit[OFS_IEN];
  assign lctl_wr = wr_hit[OFS_LCTL];
  assign mctl_wr = wr_hit[OFS_MCTL];
  assign scr_wr  = wr_hit[OFS_SCR];
  assign rbuf_rd = rd && (addr == ADDR_W'(OFS_DATA));

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)) else $error("write decode not one-hot"); // R9

  AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == ADDR_W'(OFS_IDENT) || addr == ADDR_W'(OFS_LSTAT)))
      |-> !(thr_wr || ien_wr || lctl_wr || mctl_wr || scr_wr))
    else $error("read-only offset produced a write strobe"); // R9

endmodule

// File: rtl/sio_ident.sv
module sio_ident
  import sio_intid_pkg::*;
(
  input  logic [BYTE_W-1:0] rbuf_nx,
  input  logic [BYTE_W-1:0] thold_nx,
  input  logic [BYTE_W-1:0] ien_nx,
  output logic [BYTE_W-1:0] code_nx,
  output logic [BYTE_W-1:0] status_nx
);

  always_comb begin
    code_nx   = ident_code(rbuf_nx, thold_nx, ien_nx);
    status_nx = status_byte(rbuf_nx, thold_nx);
  end

endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_intid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic              ien_wr,
  input  logic              lctl_wr,
  input  logic              mctl_wr,
  input  logic              scr_wr,
  input  logic              rbuf_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] word_hi
);

  // lane indices inside each packed word
  localparam int L_RBUF = 0, L_THOLD = 1, L_IEN = 2, L_IDENT = 3;
  localparam int L_LCTL = 0, L_MCTL  = 1, L_STAT = 2, L_SCR  = 3;

  logic [BYTE_W-1:0] lo_lane [LANES];
  logic [BYTE_W-1:0] hi_lane [LANES];

  logic [BYTE_W-1:0] rbuf_nx, thold_nx, ien_nx, code_nx, status_nx;

  // named events for the assertions
  logic rx_load_ev, rd_clear_ev, tx_done_ev;
  assign rx_load_ev  = rx_valid;
  assign rd_clear_ev = rbuf_rd && !rx_valid;
  assign tx_done_ev  = tx_valid && !thr_wr;

  always_comb begin
    rbuf_nx  = rx_load_ev ? rx_byte : (rd_clear_ev ? '0 : lo_lane[L_RBUF]);
    thold_nx = thr_wr ? wdata : (tx_done_ev ? '0 : lo_lane[L_THOLD]);
    ien_nx   = ien_wr ? wdata : lo_lane[L_IEN];
  end

  sio_ident u_ident (
    .rbuf_nx   (rbuf_nx),
    .thold_nx  (thold_nx),
    .ien_nx    (ien_nx),
    .code_nx   (code_nx),
    .status_nx (status_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_lane[L_RBUF]  <= '0;
      lo_lane[L_THOLD] <= '0;
      lo_lane[L_IEN]   <= '0;
      lo_lane[L_IDENT] <= ID_NONE;
      hi_lane[L_LCTL]  <= '0;
      hi_lane[L_MCTL]  <= '0;
      hi_lane[L_STAT]  <= status_byte('0, '0);
      hi_lane[L_SCR]   <= '0;
      tx_valid         <= 1'b0;
      tx_byte          <= '0;
    end else begin
      lo_lane[L_RBUF]  <= rbuf_nx;
      lo_lane[L_THOLD] <= thold_nx;
      lo_lane[L_IEN]   <= ien_nx;
      lo_lane[L_IDENT] <= code_nx;
      hi_lane[L_STAT]  <= status_nx;
      if (lctl_wr) hi_lane[L_LCTL] <= wdata;
      if (mctl_wr) hi_lane[L_MCTL] <= wdata;
      if (scr_wr)  hi_lane[L_SCR]  <= wdata;
      tx_valid <= thr_wr;
      if (thr_wr) tx_byte <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign word_lo[g*BYTE_W +: BYTE_W] = lo_lane[g];
    assign word_hi[g*BYTE_W +: BYTE_W] = hi_lane[g];
  end

  AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_lane[L_RBUF] != '0) && lo_lane[L_IEN][EN_RX_BIT]) |-> lo_lane[L_IDENT] == ID_RXDATA)
    else $error("receive condition not reported"); // R3

  AST_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!((lo_lane[L_RBUF] != '0) && lo_lane[L_IEN][EN_RX_BIT]) &&
     (lo_lane[L_THOLD] == '0) && lo_lane[L_IEN][EN_TX_BIT]) |-> lo_lane[L_IDENT] == ID_TXMT)
    else $error("holding-empty condition not reported"); // R4

  AST_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_lane[L_IDENT] == ID_NONE) |->
      !(((lo_lane[L_RBUF] != '0) && lo_lane[L_IEN][EN_RX_BIT]) ||
        ((lo_lane[L_THOLD] == '0) && lo_lane[L_IEN][EN_TX_BIT])))
    else $error("no-interrupt code with a live cause"); // R5

  AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (tx_valid && tx_byte == $past(wdata)))
    else $error("transmit strobe missing after holding write"); // R6

  AST_THR_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_ev |=> (lo_lane[L_THOLD] == '0))
    else $error("holding register not emptied"); // R6

  AST_RX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load_ev |=> (lo_lane[L_RBUF] == $past(rx_byte)))
    else $error("receive byte not captured"); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear_ev |=> (lo_lane[L_RBUF] == '0))
    else $error("data read did not clear buffer"); // R7

  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lane[L_STAT][ST_DR_BIT] == (lo_lane[L_RBUF] != '0)) &&
    (hi_lane[L_STAT][ST_THRE_BIT] == (lo_lane[L_THOLD] == '0)))
    else $error("line status out of step"); // R10

endmodule

// File: rtl/sio_intid.sv
module sio_intid
  import sio_intid_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        irq,
  output logic [31:0] regs_lo,
  output logic [31:0] regs_hi
);

  logic thr_wr, ien_wr, lctl_wr, mctl_wr, scr_wr, rbuf_rd;
  logic [BYTE_W-1:0] ident_q;
  logic [BYTE_W-1:0] rd_mux;

  sio_bus_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .thr_wr  (thr_wr),
    .ien_wr  (ien_wr),
    .lctl_wr (lctl_wr),
    .mctl_wr (mctl_wr),
    .scr_wr  (scr_wr),
    .rbuf_rd (rbuf_rd)
  );

  sio_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_wr   (thr_wr),
    .ien_wr   (ien_wr),
    .lctl_wr  (lctl_wr),
    .mctl_wr  (mctl_wr),
    .scr_wr   (scr_wr),
    .rbuf_rd  (rbuf_rd),
    .wdata    (bus_wdata),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .word_lo  (regs_lo),
    .word_hi  (regs_hi)
  );

  assign ident_q = regs_lo[3*BYTE_W +: BYTE_W];
  assign irq     = (ident_q != ID_NONE);

  always_comb begin
    unique case (bus_addr)
      3'd0:    rd_mux = regs_lo[0*BYTE_W +: BYTE_W];
      3'd1:    rd_mux = regs_lo[2*BYTE_W +: BYTE_W];
      3'd2:    rd_mux = regs_lo[3*BYTE_W +: BYTE_W];
      3'd3:    rd_mux = regs_hi[0*BYTE_W +: BYTE_W];
      3'd4:    rd_mux = regs_hi[1*BYTE_W +: BYTE_W];
      3'd5:    rd_mux = regs_hi[2*BYTE_W +: BYTE_W];
      3'd7:    rd_mux = regs_hi[3*BYTE_W +: BYTE_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_IRQ_TRACKS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (regs_lo[31:24] != 8'h07))
    else $error("interrupt line disagrees with code"); // R8

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_lo[31:24] == 8'h04) || (regs_lo[31:24] == 8'h02) || (regs_lo[31:24] == 8'h07))
    else $error("illegal identification code"); // R5

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata))
    else $error("read data moved without a read"); // R9

endmodule

// File: tb/sio_intid_test.sv
module sio_intid_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;
  logic [31:0] regs_lo, regs_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sio_intid uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq), .regs_lo(regs_lo), .regs_hi(regs_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_byte = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // vector: op[21:20] (0 write, 1 read, 2 receive), addr[19:17], data[16:9],
  //         expected read byte[8:1], expected irq[0]
  localparam int NV = 34;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 3'd1, 8'h01, 8'h00, 1'b0},  // R5 enable rx only
    {2'd2, 3'd0, 8'h5A, 8'h00, 1'b1},  // R3
    {2'd1, 3'd2, 8'h00, 8'h04, 1'b1},  // R3
    {2'd1, 3'd5, 8'h00, 8'h61, 1'b1},  // R10
    {2'd1, 3'd0, 8'h00, 8'h5A, 1'b0},  // R7 read clears
    {2'd1, 3'd2, 8'h00, 8'h07, 1'b0},  // R5
    {2'd0, 3'd1, 8'h02, 8'h00, 1'b1},  // R4
    {2'd1, 3'd2, 8'h00, 8'h02, 1'b1},  // R4
    {2'd0, 3'd0, 8'h33, 8'h00, 1'b0},  // R6 immediate refresh
    {2'd1, 3'd2, 8'h00, 8'h07, 1'b1},  // R6 old code read, emptied after
    {2'd1, 3'd2, 8'h00, 8'h02, 1'b1},  // R4
    {2'd0, 3'd1, 8'h03, 8'h00, 1'b1},  // R4
    {2'd2, 3'd0, 8'h11, 8'h00, 1'b1},  // R3 priority
    {2'd1, 3'd2, 8'h00, 8'h04, 1'b1},  // R3
    {2'd0, 3'd3, 8'h83, 8'h00, 1'b1},  // R9
    {2'd1, 3'd3, 8'h00, 8'h83, 1'b1},  // R9
    {2'd0, 3'd7, 8'hA5, 8'h00, 1'b1},  // R9
    {2'd1, 3'd7, 8'h00, 8'hA5, 1'b1},  // R9
    {2'd0, 3'd4, 8'h1F, 8'h00, 1'b1},  // R9
    {2'd1, 3'd4, 8'h00, 8'h1F, 1'b1},  // R9
    {2'd0, 3'd2, 8'hFF, 8'h00, 1'b1},  // R9 ignored
    {2'd1, 3'd2, 8'h00, 8'h04, 1'b1},  // R9
    {2'd0, 3'd5, 8'h00, 8'h00, 1'b1},  // R9 ignored
    {2'd1, 3'd5, 8'h00, 8'h61, 1'b1},  // R10
    {2'd0, 3'd6, 8'h77, 8'h00, 1'b1},  // R9 ignored
    {2'd1, 3'd6, 8'h00, 8'h00, 1'b1},  // R9
    {2'd1, 3'd0, 8'h00, 8'h11, 1'b1},  // R7
    {2'd1, 3'd1, 8'h00, 8'h03, 1'b1},  // R9
    {2'd0, 3'd1, 8'h00, 8'h00, 1'b0},  // R5
    {2'd0, 3'd1, 8'h01, 8'h00, 1'b0},  // R5
    {2'd2, 3'd0, 8'h00, 8'h00, 1'b0},  // R3 zero byte is not data
    {2'd1, 3'd5, 8'h00, 8'h60, 1'b0},  // R10
    {2'd1, 3'd2, 8'h00, 8'h07, 1'b0},  // R5
    {2'd1, 3'd1, 8'h00, 8'h01, 1'b0}   // R9
  };

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    check("R1 regs_lo", regs_lo, 32'h0700_0000);
    check("R1 regs_hi", regs_hi, 32'h0060_0000);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 rdata", {24'd0, bus_rdata}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    apply_reset();
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      case (v[21:20])
        2'd0: bus_write(v[19:17], v[16:9]);
        2'd1: begin
          bus_read(v[19:17]);
          check($sformatf("R9 vector %0d rdata", i), {24'd0, bus_rdata}, {24'd0, v[8:1]});
        end
        default: rx_push(v[16:9]);
      endcase
      check($sformatf("R8 vector %0d irq", i), {31'd0, irq}, {31'd0, v[0]});
    end

    // state now: ien=01, rbuf=0, thold=0, lctl=83, mctl=1F, scr=A5
    // receive and data read in the same cycle
    rx_push(8'h21);
    bus_addr = 3'd0; bus_rd = 1'b1; rx_byte = 8'h42; rx_valid = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    check("R7 collide rdata old byte", {24'd0, bus_rdata}, 32'h21);
    check("R2 R7 collide regs_lo", regs_lo, 32'h0401_0042);
    check("R3 collide irq", {31'd0, irq}, 32'd1);
    check("R2 R10 regs_hi", regs_hi, 32'hA561_1F83);

    // single transmit
    bus_write(3'd0, 8'hC3);
    check("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
    check("R6 tx_byte", {24'd0, tx_byte}, 32'hC3);
    check("R6 holding lane", {24'd0, regs_lo[15:8]}, 32'hC3);
    check("R10 status while full", {24'd0, regs_hi[23:16]}, 32'h01);
    @(negedge clk);
    check("R6 strobe one cycle", {31'd0, tx_valid}, 32'd0);
    check("R6 holding emptied", {24'd0, regs_lo[15:8]}, 32'h00);

    // back-to-back transmit
    bus_addr = 3'd0; bus_wdata = 8'h11; bus_wr = 1'b1;
    @(negedge clk);
    check("R6 first of pair", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, 8'h11});
    bus_wdata = 8'h22;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 second of pair", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, 8'h22});
    check("R6 second holds lane", {24'd0, regs_lo[15:8]}, 32'h22);
    @(negedge clk);
    check("R6 pair ends", {31'd0, tx_valid}, 32'd0);

    // reset mid-run
    apply_reset();
    check_reset_state();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule